// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat burst memory access. When the start strobe is high, it captures a complete external address. After that, each clock edge on which the active-low advance input is low moves the burst to its next beat. Only the two lowest address bits change. Every bit above them keeps the value that was loaded.

A static order input chooses how the two low bits are derived from the captured start bits and a beat count. Low selects linear order, which adds the count modulo four. High selects interleaved order, which XORs the count with the start bits. When advance is high, the address stays where it is, which inserts a wait cycle into the burst. A new load takes effect at any point in a burst and starts the count again. The address output is a register, so each input change shows up at the output one clock edge after it is sampled.

Top module: `burst_addr_seq`

## Requirements
- R1: For as long as `load_i` stays low, `addr_o[AW-1:2]` holds the upper bits of the address most recently loaded. A low-bit step never carries into or borrows from bit 2.
- R2: If `load_i` is high at an edge, `addr_o` equals the `addr_i` sampled at that edge once the edge has passed, even in the middle of a burst.
- R3: With `mode_i` = 0 (linear), each advance gives `addr_o[1:0]` = (start + k) mod 4, where k is the number of advances since the load. Start 01 gives 01, 10, 11, 00. Start 11 gives 11, 00, 01, 10.
- R4: With `mode_i` = 1 (interleaved), each advance gives `addr_o[1:0]` = start XOR k. Start 01 gives 01, 00, 11, 10. Start 10 gives 10, 11, 00, 01.
- R5: If `adv_n_i` is high and `load_i` is low at an edge, `addr_o` does not change, which is a wait cycle. The burst picks up again at the next beat on a later advance.
- R6: Once the fourth beat has been reached, one more advance returns the low bits to the start value, and the sequence then repeats.
- R7: If `load_i` and an active advance (`adv_n_i` = 0) arrive at the same edge, the load takes effect and the beat count restarts at zero.
- R8: A synchronous active-high `rst` sets `addr_o` and the beat count to zero. After reset, advances without a load step from start 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start strobe that captures `addr_i` |
| adv_n_i | input | 1 | Active-low advance; high inserts a wait cycle |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_i | input | AW | External start address |
| addr_o | output | AW | Current burst address (registered) |

## Verification
The bench checks the output after every single edge. A wrong beat count therefore appears at `addr_o[1:0]` on the edge right after the advance that caused it, either as a skipped, repeated or out-of-order beat, or as no return to the start value after four beats. If the stored start address is corrupted, or a step carries into the upper bits, `addr_o[AW-1:2]` shows the error on that same edge. The bench looks for this in runs that start at 11, because that start forces the low bits to wrap. If load priority or the wait cycles are broken, the output holds or moves on exactly the edge it should not.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  localparam int unsigned BEATS_LOG2 = 2;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [BB-1:0] cnt_o,
  output logic [BB-1:0] cnt_d_o
);
  logic [BB-1:0] cnt_q;
  logic [BB-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + BB'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign cnt_d_o = cnt_d;

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0)); // R7
  AST_CNT_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !step_i) |=> $stable(cnt_q)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && step_i && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + BB'(1))); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && step_i && (cnt_q == '1)) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] base_d_o
);
  logic [AW-1:0] base_q;

  assign base_d_o = ld_i ? addr_i : base_q;

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= base_d_o;
  end

  assign base_o = base_q;

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> $stable(base_q)); // R1
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned BB = 2
) (
  input  logic [BB-1:0] start_i,
  input  logic [BB-1:0] cnt_i,
  input  order_e        order_i,
  output logic [BB-1:0] lo_o
);
  logic [BB-1:0] lin_lo;
  logic [BB-1:0] ilv_lo;

  assign lin_lo = start_i + cnt_i;

  for (genvar b = 0; b < BB; b++) begin : g_ilv
    assign ilv_lo[b] = start_i[b] ^ cnt_i[b];
  end

  assign lo_o = (order_i == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          adv_n_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned BB = BEATS_LOG2;

  logic          step;
  logic [BB-1:0] cnt_q;
  logic [BB-1:0] cnt_d;
  logic [AW-1:0] base_q;
  logic [AW-1:0] base_d;
  logic [BB-1:0] lo_d;
  logic [AW-1:0] addr_q;
  order_e        order;

  assign step  = !adv_n_i && !load_i;
  assign order = order_e'(mode_i);

  burst_beat_ctr #(.BB(BB)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (load_i),
    .step_i  (step),
    .cnt_o   (cnt_q),
    .cnt_d_o (cnt_d)
  );

  burst_base_reg #(.AW(AW)) u_base (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (load_i),
    .addr_i   (addr_i),
    .base_o   (base_q),
    .base_d_o (base_d)
  );

  burst_order_map #(.BB(BB)) u_map (
    .start_i (base_d[BB-1:0]),
    .cnt_i   (cnt_d),
    .order_i (order),
    .lo_o    (lo_d)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= {base_d[AW-1:BB], lo_d};
  end

  assign addr_o = addr_q;

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(addr_i))); // R2
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(addr_o[AW-1:BB])); // R1
  AST_UPPER_MATCH: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (addr_o[AW-1:BB] == base_q[AW-1:BB])); // R1
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (addr_o == '0)); // R8
endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_i;
  logic          adv_n_i;
  logic          mode_i;
  logic [AW-1:0] addr_i;
  logic [AW-1:0] addr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_n_i(adv_n_i),
    .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h expected=%h at %0t", req, addr_o, exp, $time);
    end
  endtask

  // Drive inputs at the falling edge, then sample 1 ns after the next rising edge.
  task automatic cyc(input logic ld, input logic advn, input logic [AW-1:0] a);
    @(negedge clk);
    load_i  = ld;
    adv_n_i = advn;
    addr_i  = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1; load_i = 1'b0; adv_n_i = 1'b1; mode_i = 1'b0; addr_i = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset zero", '0);
    @(negedge clk);
    rst = 1'b0;
    cyc(1'b0, 1'b0, 32'hFFFF_FFFF);
    chk("R8 advance from start 00", 32'h0000_0001);
    cyc(1'b0, 1'b1, 32'h1234_5678);
    chk("R8 R5 hold after reset", 32'h0000_0001);
  endtask

  task automatic t_linear;
    logic [1:0] seq [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
    mode_i = 1'b0;
    cyc(1'b1, 1'b1, 32'hABCD_0001);
    chk("R2 linear load", 32'hABCD_0001);
    for (int k = 1; k < 4; k++) begin
      cyc(1'b0, 1'b0, 32'h0);
      chk("R3 linear beat", {30'(32'hABCD_0001 >> 2), seq[k]});
    end
    cyc(1'b0, 1'b0, 32'h0);
    chk("R6 linear wrap", 32'hABCD_0001);
  endtask

  task automatic t_linear_carry;
    logic [1:0] seq [4] = '{2'b11, 2'b00, 2'b01, 2'b10};
    mode_i = 1'b0;
    cyc(1'b1, 1'b0, 32'h0000_00FF);
    chk("R2 R7 load with advance", 32'h0000_00FF);
    for (int k = 1; k < 4; k++) begin
      cyc(1'b0, 1'b0, 32'h5555_5555);
      chk("R1 R3 no carry into upper bits", {30'(32'h0000_00FF >> 2), seq[k]});
    end
  endtask

  task automatic t_interleave;
    logic [1:0] s1 [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
    logic [1:0] s2 [4] = '{2'b10, 2'b11, 2'b00, 2'b01};
    mode_i = 1'b1;
    cyc(1'b1, 1'b1, 32'h8000_0005);
    chk("R2 interleave load", 32'h8000_0005);
    for (int k = 1; k < 4; k++) begin
      cyc(1'b0, 1'b0, 32'h0);
      chk("R4 interleave from 01", {30'(32'h8000_0005 >> 2), s1[k]});
    end
    cyc(1'b0, 1'b0, 32'h0);
    chk("R6 interleave wrap", 32'h8000_0005);
    cyc(1'b1, 1'b1, 32'h0000_CAFE);
    chk("R2 interleave reload", 32'h0000_CAFE);
    for (int k = 1; k < 4; k++) begin
      cyc(1'b0, 1'b0, 32'h0);
      chk("R4 interleave from 10", {30'(32'h0000_CAFE >> 2), s2[k]});
    end
  endtask

  task automatic t_wait;
    mode_i = 1'b0;
    cyc(1'b1, 1'b1, 32'h0F0F_0F00);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R3 first step", 32'h0F0F_0F01);
    cyc(1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R5 wait cycle 1", 32'h0F0F_0F01);
    cyc(1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R5 wait cycle 2", 32'h0F0F_0F01);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R5 resume next beat", 32'h0F0F_0F02);
  endtask

  task automatic t_load_mid;
    mode_i = 1'b1;
    cyc(1'b1, 1'b1, 32'h2222_2223);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R4 from 11 first step", 32'h2222_2222);
    cyc(1'b1, 1'b0, 32'h7777_7772);
    chk("R7 load beats advance", 32'h7777_7772);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R7 count restarted", 32'h7777_7773);
    cyc(1'b0, 1'b0, 32'h0);
    chk("R4 R7 third beat", 32'h7777_7770);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_linear();
    t_linear_carry();
    t_interleave();
    t_wait();
    t_load_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule